// File: doc/BRIEF.md
# Predicate and Condition-Code Unit

This block holds the per-thread single-bit predicates and the four arithmetic condition flags of a shader core. In each cycle it looks up the guard predicate named by the issuing instruction, optionally inverts it, and returns the execute-enable for that instruction. Three agents can change the stored state: a single predicate write from a compare operation, a flag update from an arithmetic instruction that carries the set-flags option, and a masked bulk load from a 32-bit general register. A bulk read packs either the predicates or the flags into a 32-bit register value.

The arithmetic that produces the flag values is outside the block, and the flags arrive ready-made on an input. The guard lookup and the bulk read are combinational on the stored state. All writes take effect at the next rising clock edge, so an instruction whose guard is evaluated in the same cycle as a write still sees the old value.

Top module: `pcc_unit`

## Requirements
- R1: A synchronous active-high reset clears all five predicates and all four flags to zero.
- R2: A predicate write (`pw_en`) with id 0 to 4 stores `pw_val` into that predicate at the next edge. Writes to ids 5, 6 and 7 leave every predicate unchanged.
- R3: Guard ids 0 to 4 read the stored predicate, id 7 reads constant one, and ids 5 and 6 read constant zero. `exec_en` equals that value XOR `gd_neg`.
- R4: The guard lookup uses the state held before the current cycle's writes. A write takes effect in `exec_en` only in the following cycle.
- R5: The flags load `cc_in` only when `cc_issue` and `cc_setcc` are both high. With `cc_setcc` low the flags hold. The flag encoding is zero in bit 0, sign in bit 1, carry in bit 2 and overflow in bit 3.
- R6: `mv_rdata` holds the predicates in bits 4..0 when `mv_sel` = 0, or the flags in bits 3..0 when `mv_sel` = 1. Every other bit reads zero.
- R7: A bulk load (`ld_en`) to the target chosen by `ld_sel` (0 = predicates, 1 = flags) replaces only the target bits whose `ld_mask` bit is set, with the same-numbered bit of `ld_data`. Mask bits above the target width have no effect.
- R8: A bulk load to one target never changes the other target.
- R9: When a predicate write and a bulk load to the predicates hit the same bit in one cycle, the predicate write wins.
- R10: When a set-flags update and a bulk load to the flags occur in one cycle, the set-flags update wins for all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gd_id | input | 3 | Guard predicate id |
| gd_neg | input | 1 | Invert guard |
| exec_en | output | 1 | Instruction execute-enable |
| pw_en | input | 1 | Single predicate write strobe |
| pw_id | input | 3 | Predicate id to write |
| pw_val | input | 1 | Predicate write value |
| cc_issue | input | 1 | Flag-producing instruction issued |
| cc_setcc | input | 1 | Set-flags option of that instruction |
| cc_in | input | 4 | New flags {overflow, carry, sign, zero} |
| mv_sel | input | 1 | Bulk read source: 0 predicates, 1 flags |
| mv_rdata | output | 32 | Packed bulk read value |
| ld_en | input | 1 | Bulk load strobe |
| ld_sel | input | 1 | Bulk load target: 0 predicates, 1 flags |
| ld_data | input | 32 | Bulk load source register value |
| ld_mask | input | 32 | Bulk load bit mask |
| pred_q | output | 5 | Stored predicates |
| cc_q | output | 4 | Stored flags |

## Verification
Two pairs of operations can fall in the same cycle. A single predicate write and a bulk load can target the same predicate bit, and a set-flags update and a bulk load can both target the flags. The bench drives each pair in one cycle with conflicting values and then reads the stored state, expecting the value of the single write or of the set-flags update. The bench also evaluates a guard in the cycle that writes its predicate. It checks that `exec_en` shows the old value before the edge and the new value after it.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int NUM_PRED = 5;
    localparam int NUM_FLAG = 4;
    localparam int ID_W     = 3;
    localparam int REG_W    = 32;

    localparam logic [ID_W-1:0] ID_ONE  = 3'd7;
    localparam logic [ID_W-1:0] ID_ZERO = 3'd6;

    typedef enum logic {
        SRC_PRED = 1'b0,
        SRC_FLAG = 1'b1
    } src_e;

    typedef struct packed {
        logic ovf;
        logic carry;
        logic sign;
        logic zero;
    } flags_t;

    function automatic logic guard_lookup(
        input logic [NUM_PRED-1:0] preds,
        input logic [ID_W-1:0]     id
    );
        logic v;
        if (id == ID_ONE)
            v = 1'b1;
        else if (int'(id) < NUM_PRED)
            v = preds[id];
        else
            v = 1'b0;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] widen_pred(input logic [NUM_PRED-1:0] p);
        logic [REG_W-1:0] w;
        w = '0;
        w[NUM_PRED-1:0] = p;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] widen_flag(input flags_t f);
        logic [REG_W-1:0] w;
        w = '0;
        w[NUM_FLAG-1:0] = f;
        return w;
    endfunction

endpackage

// File: rtl/pcc_pred_file.sv
module pcc_pred_file
    import pcc_pkg::*;
#(
    parameter int NP  = NUM_PRED,
    parameter int IDW = ID_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [IDW-1:0] wr_id,
    input  logic           wr_val,
    input  logic           ld_en,
    input  logic [NP-1:0]  ld_data,
    input  logic [NP-1:0]  ld_mask,
    output logic [NP-1:0]  q
);

    for (genvar i = 0; i < NP; i++) begin : g_bit
        logic hit_wr;
        logic hit_ld;
        assign hit_wr = wr_en && (wr_id == IDW'(i));
        assign hit_ld = ld_en && ld_mask[i];

        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (hit_wr)
                q[i] <= wr_val;
            else if (hit_ld)
                q[i] <= ld_data[i];
        end
    end

endmodule

// File: rtl/pcc_flag_reg.sv
module pcc_flag_reg
    import pcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                upd,
    input  flags_t              upd_val,
    input  logic                ld_en,
    input  logic [NUM_FLAG-1:0] ld_data,
    input  logic [NUM_FLAG-1:0] ld_mask,
    output flags_t              q
);

    logic [NUM_FLAG-1:0] cur;
    logic [NUM_FLAG-1:0] nxt_upd;

    assign nxt_upd = upd_val;
    assign q       = cur;

    for (genvar i = 0; i < NUM_FLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                cur[i] <= 1'b0;
            else if (upd)
                cur[i] <= nxt_upd[i];
            else if (ld_en && ld_mask[i])
                cur[i] <= ld_data[i];
        end
    end

endmodule

// File: rtl/pcc_guard_eval.sv
module pcc_guard_eval
    import pcc_pkg::*;
(
    input  logic [NUM_PRED-1:0] preds,
    input  logic [ID_W-1:0]     id,
    input  logic                neg,
    output logic                en
);

    logic raw;

    always_comb begin
        raw = guard_lookup(preds, id);
        en  = raw ^ neg;
    end

endmodule

// File: rtl/pcc_unit.sv
module pcc_unit
    import pcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ID_W-1:0]     gd_id,
    input  logic                gd_neg,
    output logic                exec_en,
    input  logic                pw_en,
    input  logic [ID_W-1:0]     pw_id,
    input  logic                pw_val,
    input  logic                cc_issue,
    input  logic                cc_setcc,
    input  logic [NUM_FLAG-1:0] cc_in,
    input  logic                mv_sel,
    output logic [REG_W-1:0]    mv_rdata,
    input  logic                ld_en,
    input  logic                ld_sel,
    input  logic [REG_W-1:0]    ld_data,
    input  logic [REG_W-1:0]    ld_mask,
    output logic [NUM_PRED-1:0] pred_q,
    output logic [NUM_FLAG-1:0] cc_q
);

    src_e   ld_src;
    src_e   rd_src;
    logic   ld_to_pred;
    logic   ld_to_flag;
    logic   flag_upd;
    flags_t flag_in;
    flags_t flag_st;

    assign ld_src     = src_e'(ld_sel);
    assign rd_src     = src_e'(mv_sel);
    assign ld_to_pred = ld_en && (ld_src == SRC_PRED);
    assign ld_to_flag = ld_en && (ld_src == SRC_FLAG);
    assign flag_upd   = cc_issue && cc_setcc;
    assign flag_in    = flags_t'(cc_in);

    pcc_pred_file #(.NP(NUM_PRED), .IDW(ID_W)) u_pred (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pw_en),
        .wr_id   (pw_id),
        .wr_val  (pw_val),
        .ld_en   (ld_to_pred),
        .ld_data (ld_data[NUM_PRED-1:0]),
        .ld_mask (ld_mask[NUM_PRED-1:0]),
        .q       (pred_q)
    );

    pcc_flag_reg u_flag (
        .clk     (clk),
        .rst     (rst),
        .upd     (flag_upd),
        .upd_val (flag_in),
        .ld_en   (ld_to_flag),
        .ld_data (ld_data[NUM_FLAG-1:0]),
        .ld_mask (ld_mask[NUM_FLAG-1:0]),
        .q       (flag_st)
    );

    pcc_guard_eval u_guard (
        .preds (pred_q),
        .id    (gd_id),
        .neg   (gd_neg),
        .en    (exec_en)
    );

    assign cc_q = flag_st;

    always_comb begin
        unique case (rd_src)
            SRC_PRED: mv_rdata = widen_pred(pred_q);
            SRC_FLAG: mv_rdata = widen_flag(flag_st);
            default:  mv_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pcc_unit_chk.sv
module pcc_unit_chk
    import pcc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ID_W-1:0]     gd_id,
    input logic                gd_neg,
    input logic                exec_en,
    input logic                pw_en,
    input logic [ID_W-1:0]     pw_id,
    input logic                pw_val,
    input logic                cc_issue,
    input logic                cc_setcc,
    input logic [NUM_FLAG-1:0] cc_in,
    input logic                mv_sel,
    input logic [REG_W-1:0]    mv_rdata,
    input logic                ld_en,
    input logic                ld_sel,
    input logic [REG_W-1:0]    ld_data,
    input logic [REG_W-1:0]    ld_mask,
    input logic [NUM_PRED-1:0] pred_q,
    input logic [NUM_FLAG-1:0] cc_q
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pred_q == '0) && (cc_q == '0));

    a_r3_const_one: assert property (@(posedge clk) disable iff (rst)
        (gd_id == ID_ONE) |-> (exec_en == !gd_neg));

    a_r3_const_zero: assert property (@(posedge clk) disable iff (rst)
        (gd_id == ID_ZERO) |-> (exec_en == gd_neg));

    a_r5_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !(cc_issue && cc_setcc) && !(ld_en && ld_sel) |=> $stable(cc_q));

    a_r5_flags_load: assert property (@(posedge clk) disable iff (rst)
        (cc_issue && cc_setcc) |=> (cc_q == $past(cc_in)));

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        mv_rdata[REG_W-1:NUM_PRED] == '0);

    a_r8_flag_load_keeps_preds: assert property (@(posedge clk) disable iff (rst)
        !pw_en && !(ld_en && !ld_sel) |=> $stable(pred_q));

    a_r9_single_write_wins: assert property (@(posedge clk) disable iff (rst)
        (pw_en && (int'(pw_id) < NUM_PRED)) |=> (pred_q[$past(pw_id)] == $past(pw_val)));

endmodule

bind pcc_unit pcc_unit_chk u_chk (.*);

// File: tb/tb_pcc_unit.sv
module tb_pcc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  gd_id;
    logic        gd_neg;
    logic        exec_en;
    logic        pw_en;
    logic [2:0]  pw_id;
    logic        pw_val;
    logic        cc_issue;
    logic        cc_setcc;
    logic [3:0]  cc_in;
    logic        mv_sel;
    logic [31:0] mv_rdata;
    logic        ld_en;
    logic        ld_sel;
    logic [31:0] ld_data;
    logic [31:0] ld_mask;
    logic [4:0]  pred_q;
    logic [3:0]  cc_q;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pcc_unit dut (.*);

    typedef struct packed {
        logic        pw_en;
        logic [2:0]  pw_id;
        logic        pw_val;
        logic        iss;
        logic        setcc;
        logic [3:0]  cc;
        logic        ld_en;
        logic        ld_sel;
        logic [31:0] ld_data;
        logic [31:0] ld_mask;
        logic [4:0]  exp_pred;
        logic [3:0]  exp_cc;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        {1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 32'h0, 5'b00100, 4'h0}, // R2 write id2
        {1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 32'h0, 5'b00100, 4'h0}, // R2 id7 ignored
        {1'b1, 3'd6, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 32'h0, 5'b00100, 4'h0}, // R2 id6 ignored
        {1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 32'h0, 32'h0, 5'b00100, 4'h0}, // R5 no setcc
        {1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 4'h5, 1'b0, 1'b0, 32'h0, 32'h0, 5'b00100, 4'h5}, // R5 setcc
        {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h3, 5'b00111, 4'h5}, // R7 R8
        {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 32'h0, 32'h4, 5'b00011, 4'h5},         // R7 clear
        {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 32'hA, 32'hF, 5'b00011, 4'hA},         // R7 flags R8
        {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 32'h0, 32'hFFFF_FFF0, 5'b00011, 4'hA}, // R7 high mask
        {1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 32'h1, 32'h1, 5'b00010, 4'hA},         // R9
        {1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 4'h3, 1'b1, 1'b1, 32'hC, 32'hF, 5'b00010, 4'h3},         // R10
        {1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 32'h0, 5'b00010, 4'h3},         // R2 id5
        {1'b1, 3'd4, 1'b1, 1'b1, 1'b1, 4'h9, 1'b0, 1'b0, 32'h0, 32'h0, 5'b10010, 4'h9}          // R2 R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        pw_en = 0; pw_id = 0; pw_val = 0;
        cc_issue = 0; cc_setcc = 0; cc_in = 0;
        ld_en = 0; ld_sel = 0; ld_data = 0; ld_mask = 0;
    endtask

    function automatic logic model_guard(input logic [4:0] p, input logic [2:0] id, input logic n);
        logic v;
        if (id == 3'd7) v = 1'b1;
        else if (id < 3'd5) v = p[id];
        else v = 1'b0;
        return v ^ n;
    endfunction

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        gd_id = 0; gd_neg = 0; mv_sel = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1 pred", 32'(pred_q), 32'h0);
        check("R1 cc", 32'(cc_q), 32'h0);
        rst = 0;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            pw_en = VECS[k].pw_en; pw_id = VECS[k].pw_id; pw_val = VECS[k].pw_val;
            cc_issue = VECS[k].iss; cc_setcc = VECS[k].setcc; cc_in = VECS[k].cc;
            ld_en = VECS[k].ld_en; ld_sel = VECS[k].ld_sel;
            ld_data = VECS[k].ld_data; ld_mask = VECS[k].ld_mask;
            @(negedge clk);
            idle_inputs();
            check($sformatf("R2/R5/R7-R10 vec%0d pred", k), 32'(pred_q), 32'(VECS[k].exp_pred));
            check($sformatf("R2/R5/R7-R10 vec%0d cc", k), 32'(cc_q), 32'(VECS[k].exp_cc));
        end

        // R3: guard sweep over all ids and both polarities, preds = 10010
        for (int id = 0; id < 8; id++) begin
            for (int n = 0; n < 2; n++) begin
                gd_id = 3'(id); gd_neg = 1'(n);
                #1;
                check($sformatf("R3 id%0d neg%0d", id, n), 32'(exec_en),
                      32'(model_guard(5'b10010, 3'(id), 1'(n))));
            end
        end

        // R6: packed reads
        mv_sel = 0; #1;
        check("R6 pred pack", mv_rdata, 32'h0000_0012);
        mv_sel = 1; #1;
        check("R6 flag pack", mv_rdata, 32'h0000_0009);

        // R4: guard sees old value during the write cycle
        @(negedge clk);
        gd_id = 3'd4; gd_neg = 0;
        pw_en = 1; pw_id = 3'd4; pw_val = 0;
        #1;
        check("R4 old value", 32'(exec_en), 32'h1);
        @(negedge clk);
        idle_inputs();
        #1;
        check("R4 new value", 32'(exec_en), 32'h0);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 mid pred", 32'(pred_q), 32'h0);
        check("R1 mid cc", 32'(cc_q), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule